// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a small read cache. Its main array is direct-mapped: each line address selects exactly one set. A small fully associative victim buffer sits beside the main array and keeps lines that were recently pushed out of it. A request that misses the main array is looked up in the victim buffer before anything goes to the next memory level.

On a victim hit, the buffered line and the line that currently occupies its set trade places in a single cycle, and no fetch is issued. When both structures miss, the block sends one line-address request to the next level and waits for the response. The returned line is installed in the main array, and the line it displaces is written over the oldest victim entry.

Each accepted request produces one response pulse. The pulse carries the line data and a result kind (main hit, victim hit or miss), so a testbench can count the results directly.

Top module: `dm_victim_cache`

## Requirements
- R1: A byte address splits into three fields. The low log2(LINE_BYTES) bits are the offset and do not affect the lookup. The next log2(SETS) bits are the set index. The remaining high bits are the tag. The line address is the address with the offset removed.
- R2: A request that hits the main array gives resp_valid in the cycle after acceptance, with resp_kind = 2'b01 and the line's data. It issues no next-level request.
- R3: A request that misses both structures raises mem_req_valid for exactly one cycle, starting the cycle after acceptance, with mem_req_addr equal to the line address. In the cycle after mem_resp_valid, the block gives resp_valid with resp_kind = 2'b11 and the fetched data, and the line is installed in the main array.
- R4: Every valid line displaced from the main array is placed in the victim buffer.
- R5: The victim buffer is searched before the next level. A request whose line sits in the victim buffer gives resp_valid one cycle after acceptance, with resp_kind = 2'b10 and the correct data, and no next-level request.
- R6: A victim hit swaps lines in one cycle. The requested line moves into its main set, so the next access to it is a main hit. The line it displaced moves into the same victim entry, so an access to that line is a victim hit.
- R7: When a miss displaces a line, the displaced line overwrites the victim entries in FIFO order (the oldest written entry first). A line whose entry has been overwritten misses, and the lines that remain still give victim hits.
- R8: While a miss is outstanding, req_ready is low and a request presented on the port is ignored: it produces no response, no fetch and no change of cache contents.
- R9: After reset, every entry of both structures is invalid, req_ready is high, and resp_valid and mem_req_valid are low. The first access misses.
- R10: resp_valid is a one-cycle pulse for each accepted request, and resp_kind is never 2'b00 while resp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_ready | output | 1 | High when a request can be accepted |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_kind | output | 2 | 01 main hit, 10 victim hit, 11 miss |
| resp_data | output | LINE_BYTES*8 | Requested line |
| mem_req_valid | output | 1 | One-cycle fetch request to next level |
| mem_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address to fetch |
| mem_resp_valid | input | 1 | Next-level line returned |
| mem_resp_data | input | LINE_BYTES*8 | Returned line |

## Verification
The bench forces two lines into the same set and then alternates between them. A design that did not swap would keep the conflict lines in the wrong structure and report misses or the wrong kind. It then pushes more displacements than the buffer holds and checks that the oldest victim is the one lost. A LIFO design, or one that overwrote the last-used slot, would lose a different line. Finally, it drives a request that would hit the main array while a fetch is outstanding. A design that accepted that request would emit a stray response or corrupt the pending fill.

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int SETS       = 8,
  parameter int VICT_N     = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid,
  input  logic [ADDR_W-1:0]                       req_addr,
  output logic                                    req_ready,
  output logic                                    resp_valid,
  output logic [1:0]                              resp_kind,
  output logic [LINE_BYTES*8-1:0]                 resp_data,
  output logic                                    mem_req_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    mem_req_addr,
  input  logic                                    mem_resp_valid,
  input  logic [LINE_BYTES*8-1:0]                 mem_resp_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = LA_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int VW     = (VICT_N > 1) ? $clog2(VICT_N) : 1;
  localparam logic [1:0] K_HIT = 2'b01, K_VHIT = 2'b10, K_MISS = 2'b11;

  logic [SETS-1:0]   m_valid;
  logic [TAG_W-1:0]  m_tag  [SETS];
  logic [LINE_W-1:0] m_data [SETS];

  logic [VICT_N-1:0] v_valid;
  logic [LA_W-1:0]   v_la   [VICT_N];
  logic [LINE_W-1:0] v_data [VICT_N];
  logic [VW-1:0]     v_wp;

  logic              pending;
  logic [LA_W-1:0]   p_la;

  wire [LA_W-1:0]  q_la   = req_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0] q_idx  = q_la[IDX_W-1:0];
  wire [TAG_W-1:0] q_tag  = q_la[LA_W-1:IDX_W];
  wire [IDX_W-1:0] f_idx  = p_la[IDX_W-1:0];
  wire             accept = req_valid && !pending;
  wire             m_hit  = m_valid[q_idx] && (m_tag[q_idx] == q_tag);
  wire             fill   = pending && mem_resp_valid;

  logic unused_off;
  assign unused_off = ^req_addr[OFF_W-1:0];

  assign req_ready    = !pending;
  assign mem_req_addr = p_la;

  logic          v_hit;
  logic [VW-1:0] v_sel;
  always_comb begin
    v_hit = 1'b0;
    v_sel = '0;
    for (int i = 0; i < VICT_N; i++)
      if (v_valid[i] && v_la[i] == q_la) begin
        v_hit = 1'b1;
        v_sel = VW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid       <= '0;
      v_valid       <= '0;
      v_wp          <= '0;
      pending       <= 1'b0;
      p_la          <= '0;
      mem_req_valid <= 1'b0;
      resp_valid    <= 1'b0;
      resp_kind     <= 2'b00;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      if (accept) begin
        if (m_hit) begin
          resp_valid <= 1'b1;
          resp_kind  <= K_HIT;
        end else if (v_hit) begin
          resp_valid       <= 1'b1;
          resp_kind        <= K_VHIT;
          m_valid[q_idx]   <= 1'b1;
          v_valid[v_sel]   <= m_valid[q_idx];
        end else begin
          pending       <= 1'b1;
          p_la          <= q_la;
          mem_req_valid <= 1'b1;
        end
      end else if (fill) begin
        pending        <= 1'b0;
        resp_valid     <= 1'b1;
        resp_kind      <= K_MISS;
        m_valid[f_idx] <= 1'b1;
        if (m_valid[f_idx]) begin
          v_valid[v_wp] <= 1'b1;
          v_wp <= (v_wp == VW'(VICT_N - 1)) ? '0 : v_wp + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && m_hit) begin
      resp_data <= m_data[q_idx];
    end else if (accept && v_hit) begin
      resp_data      <= v_data[v_sel];
      m_tag[q_idx]   <= q_tag;
      m_data[q_idx]  <= v_data[v_sel];
      v_la[v_sel]    <= {m_tag[q_idx], q_idx};
      v_data[v_sel]  <= m_data[q_idx];
    end else if (fill) begin
      resp_data      <= mem_resp_data;
      m_tag[f_idx]   <= p_la[LA_W-1:IDX_W];
      m_data[f_idx]  <= mem_resp_data;
      if (m_valid[f_idx]) begin
        v_la[v_wp]   <= {m_tag[f_idx], f_idx};
        v_data[v_wp] <= m_data[f_idx];
      end
    end
  end
endmodule

module dm_victim_cache_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       resp_valid,
  input logic [1:0] resp_kind,
  input logic       mem_req_valid,
  input logic       mem_resp_valid
);
  p_kind_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_kind != 2'b00);

  p_fetch_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_miss_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind == 2'b11) |-> $past(mem_resp_valid));

  p_fast_from_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind != 2'b11) |-> $past(req_valid && req_ready));

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (resp_valid != mem_req_valid));

  p_busy_while_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
endmodule

bind dm_victim_cache dm_victim_cache_chk u_chk (.*);

// File: tb/dm_victim_cache_bench.sv
`timescale 1ns/1ps
module dm_victim_cache_bench;
  localparam logic [1:0] K_HIT = 2'b01, K_VHIT = 2'b10, K_MISS = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, resp_valid, mem_req_valid;
  logic [1:0]  resp_kind;
  logic [63:0] resp_data;
  logic [12:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [63:0] mem_resp_data = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dm_victim_cache u_dm_victim_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .resp_data(resp_data), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data)
  );

  function automatic logic [15:0] mk(input int tag, input int idx, input int off);
    return 16'((tag << 6) | (idx << 3) | off);
  endfunction

  function automatic logic [63:0] ldata(input logic [12:0] la);
    return {3'b000, la, 16'hC0DE, 3'b000, ~la, 16'h5A5A};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic serve(input logic [12:0] la, input string r);
    repeat (2) @(negedge clk);
    mem_resp_valid = 1'b1;
    mem_resp_data  = ldata(la);
    @(negedge clk);
    mem_resp_valid = 1'b0;
    chk({r, " miss resp_valid"}, 64'(resp_valid), 64'd1);
    chk({r, " miss kind"}, 64'(resp_kind), 64'(K_MISS));
    chk({r, " miss data"}, resp_data, ldata(la));
  endtask

  task automatic access(input logic [15:0] a, input logic [1:0] exp, input string r);
    logic [12:0] la;
    la = a[15:3];
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp != K_MISS) begin
      chk({r, " resp_valid"}, 64'(resp_valid), 64'd1);
      chk({r, " kind"}, 64'(resp_kind), 64'(exp));
      chk({r, " data"}, resp_data, ldata(la));
      chk({r, " no fetch"}, 64'(mem_req_valid), 64'd0);
    end else begin
      chk({r, " fetch issued"}, 64'(mem_req_valid), 64'd1);
      chk({r, " fetch addr"}, 64'(mem_req_addr), 64'(la));
      chk({r, " busy"}, 64'(req_ready), 64'd0);
      serve(la, r);
    end
    @(negedge clk);
    chk("R10 resp pulse ends", 64'(resp_valid), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 ready after reset", 64'(req_ready), 64'd1);
    chk("R9 no resp after reset", 64'(resp_valid), 64'd0);
    chk("R9 no fetch after reset", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_basic();
    access(mk(1, 2, 0), K_MISS, "R9 first access");
    access(mk(1, 2, 5), K_HIT,  "R1 offset ignored R2 hit");
    access(mk(1, 3, 0), K_MISS, "R1 other index R3");
    access(mk(1, 3, 7), K_HIT,  "R2 hit");
  endtask

  task automatic t_swap();
    access(mk(2, 2, 0), K_MISS, "R3 conflict fill");
    access(mk(1, 2, 1), K_VHIT, "R4 R5 evicted line in victim");
    access(mk(1, 2, 0), K_HIT,  "R6 swapped into main");
    access(mk(2, 2, 3), K_VHIT, "R6 displaced into victim");
  endtask

  task automatic t_fifo();
    for (int t = 1; t <= 5; t++) access(mk(t, 4, 0), K_MISS, "R7 fill set 4");
    access(mk(1, 2, 0), K_MISS, "R7 oldest entry overwritten");
    access(mk(3, 4, 0), K_VHIT, "R7 younger entry kept");
  endtask

  task automatic t_ignore();
    logic [12:0] la;
    la = mk(7, 6, 0) >> 3;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = mk(7, 6, 0);
    @(negedge clk);
    chk("R8 fetch issued", 64'(mem_req_valid), 64'd1);
    req_addr = mk(1, 3, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 ignored no resp", 64'(resp_valid), 64'd0);
    chk("R8 ignored no fetch", 64'(mem_req_valid), 64'd0);
    chk("R8 still busy", 64'(req_ready), 64'd0);
    mem_resp_valid = 1'b1;
    mem_resp_data  = ldata(la);
    @(negedge clk);
    mem_resp_valid = 1'b0;
    chk("R8 pending miss kind", 64'(resp_kind), 64'(K_MISS));
    chk("R8 pending miss data", resp_data, ldata(la));
    access(mk(1, 3, 0), K_HIT, "R8 contents unchanged");
    access(mk(7, 6, 2), K_HIT, "R8 fill installed");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_swap();
    t_fifo();
    t_ignore();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule